// File: doc/BRIEF.md
# System Clock Source Switch with Stability Qualification

This block chooses which of five clock sources drives the system clock. The five are a fast crystal, a slow crystal, a PLL, a slow RC oscillator and a fast RC oscillator. Each source is modelled as a tick enable in one reference clock domain. Each source has its own stability counter. The counter starts when the source is enabled, advances on that source's ticks, and raises the source's stable flag once it reaches its programmed length. The fast crystal and the slow crystal share one fixed length. The PLL length comes from one select bit. The fast RC length comes from a two-bit field. The slow RC length is a parameter.

A switch request carries a 3-bit select code. A small state machine handles it in four states:
- `SW_IDLE` waits for a request. On `req_valid` it latches the code and moves to `SW_EVAL`.
- `SW_EVAL` decodes the code and checks the target's stable flag. It goes to `SW_TAKE` if the code is legal and the target is stable. Otherwise it goes to `SW_REFUSE`.
- `SW_TAKE` installs the new source, clears the fail flag and returns to `SW_IDLE`.
- `SW_REFUSE` keeps the current source, sets the fail flag and returns to `SW_IDLE`.

A request is sampled only in `SW_IDLE`. Its outcome is visible on the outputs after the third rising clock edge, counting the edge that samples the request. Software clears the sticky fail flag by pulsing `fail_clr`.

Top module: `clksrc_switch`

## Requirements
- R1: After reset, `active_sel` is 3'b111 (the fast RC), `src_stable` is all zero and `fail_flag` is 0. `active_sel` only ever holds a legal select code.
- R2: With the fast crystal (bit 0) enabled, its stable flag rises exactly on the 4096th tick (parameter `XTAL_CNT`). The slow crystal (bit 1) uses the same length.
- R3: The fast RC (bit 4) becomes stable after a number of ticks set by `hrc_cnt_sel`: 00 gives 512, 01 gives 1024, 10 gives 2048 and 11 gives 256.
- R4: The PLL (bit 2) becomes stable after 6144 ticks when `pll_cnt_sel` is 0, and after 16128 ticks when it is 1.
- R5: The slow RC (bit 3) becomes stable after `LRC_CNT` ticks (default 128).
- R6: A disabled source reads 0 on its stable flag. After re-enable it counts again from zero, even if it was disabled part way through a count.
- R7: Select codes map to sources as 000 fast crystal, 001 slow crystal, 010 PLL, 011 slow RC and 111 fast RC. A request for a stable source sets `active_sel` to that code.
- R8: A request for a legal source that is not stable sets `fail_flag` and leaves `active_sel` unchanged.
- R9: A request with a reserved code (100, 101 or 110) is refused like a request for an unstable source.
- R10: `fail_flag` stays set until a `fail_clr` pulse clears it on the next edge. A refusal in the same cycle wins over the clear.
- R11: A successful switch clears `fail_flag`.
- R12: Stability counters advance only on cycles where their source's tick is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_en | input | 5 | Source enables; bit order: fast crystal, slow crystal, PLL, slow RC, fast RC |
| src_tick | input | 5 | Per-source tick enables, same bit order |
| req_sel | input | 3 | Requested select code |
| req_valid | input | 1 | One-cycle switch request strobe |
| hrc_cnt_sel | input | 2 | Fast RC stability length field |
| pll_cnt_sel | input | 1 | PLL stability length select |
| fail_clr | input | 1 | Clears the fail flag |
| active_sel | output | 3 | Select code of the source in use |
| src_stable | output | 5 | Per-source stable flags |
| fail_flag | output | 1 | Sticky switch-failure flag |

## Verification
The assertions check on every cycle that the active code stays legal and that a fail flag rising never coincides with a change of source. They also check that a successful change never leaves the flag set, and that no stable flag rises without its source enabled and ticking in the preceding cycle.

The exact stability lengths for each setting need the bench's directed scenarios. So do the restart after a mid-count disable, the stretched count under sparse ticks, the code-to-source mapping, reserved-code refusal and the sticky clear.

// File: rtl/clksrc_pkg.sv
package clksrc_pkg;

    localparam int NSRC = 5;

    // source indices (bit positions in enable/tick/stable vectors)
    localparam int IX_HXT = 0;
    localparam int IX_LXT = 1;
    localparam int IX_PLL = 2;
    localparam int IX_LRC = 3;
    localparam int IX_HRC = 4;

    // select codes
    localparam logic [2:0] SEL_HXT = 3'b000;
    localparam logic [2:0] SEL_LXT = 3'b001;
    localparam logic [2:0] SEL_PLL = 3'b010;
    localparam logic [2:0] SEL_LRC = 3'b011;
    localparam logic [2:0] SEL_HRC = 3'b111;

    typedef enum logic [1:0] {
        SW_IDLE,
        SW_EVAL,
        SW_TAKE,
        SW_REFUSE
    } sw_state_t;

    typedef struct packed {
        logic       ok;
        logic [2:0] idx;
    } sel_dec_t;

    function automatic sel_dec_t decode_sel(input logic [2:0] code);
        sel_dec_t d;
        d = '{ok: 1'b1, idx: 3'd0};
        case (code)
            SEL_HXT: d.idx = 3'(IX_HXT);
            SEL_LXT: d.idx = 3'(IX_LXT);
            SEL_PLL: d.idx = 3'(IX_PLL);
            SEL_LRC: d.idx = 3'(IX_LRC);
            SEL_HRC: d.idx = 3'(IX_HRC);
            default: d.ok  = 1'b0;
        endcase
        return d;
    endfunction

    function automatic int hrc_limit(input logic [1:0] field);
        case (field)
            2'b00:   return 512;
            2'b01:   return 1024;
            2'b10:   return 2048;
            default: return 256;
        endcase
    endfunction

    function automatic int pll_limit(input logic long_sel);
        return long_sel ? 16128 : 6144;
    endfunction

endpackage

// File: rtl/clksrc_stab_cnt.sv
module clksrc_stab_cnt #(
    parameter int CNT_W = 15
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             tick,
    input  logic [CNT_W-1:0] limit,
    output logic             stable
);

    logic [CNT_W-1:0] cnt;
    logic             done;
    logic [CNT_W:0]   cnt_inc;

    assign cnt_inc = {1'b0, cnt} + 1'b1;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt  <= '0;
            done <= 1'b0;
        end else if (!en) begin
            // disabled: forget progress so the next enable restarts
            cnt  <= '0;
            done <= 1'b0;
        end else if (!done && tick) begin
            cnt <= cnt_inc[CNT_W-1:0];
            if (cnt_inc >= {1'b0, limit}) begin
                done <= 1'b1;
            end
        end
    end

    assign stable = done & en;

endmodule

// File: rtl/clksrc_sw_fsm.sv
module clksrc_sw_fsm
    import clksrc_pkg::*;
#(
    parameter logic [2:0] BOOT_SEL = SEL_HRC
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    input  logic [2:0]      req_sel,
    input  logic [NSRC-1:0] stable,
    input  logic            fail_clr,
    output logic [2:0]      active_sel,
    output logic            fail_flag
);

    sw_state_t  st, st_nx;
    logic [2:0] tgt_sel;
    sel_dec_t   dec;
    logic       tgt_ready;

    assign dec       = decode_sel(tgt_sel);
    assign tgt_ready = dec.ok && stable[dec.idx];

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= SW_IDLE;
        end else begin
            st <= st_nx;
        end
    end

    // transitions
    always_comb begin
        st_nx = st;
        unique case (st)
            SW_IDLE:   if (req_valid) st_nx = SW_EVAL;
            SW_EVAL:   st_nx = tgt_ready ? SW_TAKE : SW_REFUSE;
            SW_TAKE:   st_nx = SW_IDLE;
            SW_REFUSE: st_nx = SW_IDLE;
        endcase
    end

    // outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_sel <= BOOT_SEL;
            fail_flag  <= 1'b0;
            tgt_sel    <= '0;
        end else begin
            unique case (st)
                SW_IDLE: begin
                    if (req_valid) tgt_sel <= req_sel;
                    if (fail_clr)  fail_flag <= 1'b0;
                end
                SW_EVAL: begin
                    if (fail_clr) fail_flag <= 1'b0;
                end
                SW_TAKE: begin
                    active_sel <= tgt_sel;
                    fail_flag  <= 1'b0;
                end
                SW_REFUSE: begin
                    fail_flag <= 1'b1;   // set beats clear
                end
            endcase
        end
    end

endmodule

// File: rtl/clksrc_switch.sv
module clksrc_switch
    import clksrc_pkg::*;
#(
    parameter int         CNT_W    = 15,
    parameter int         XTAL_CNT = 4096,
    parameter int         LRC_CNT  = 128,
    parameter logic [2:0] BOOT_SEL = SEL_HRC
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [4:0] src_en,
    input  logic [4:0] src_tick,
    input  logic [2:0] req_sel,
    input  logic       req_valid,
    input  logic [1:0] hrc_cnt_sel,
    input  logic       pll_cnt_sel,
    input  logic       fail_clr,
    output logic [2:0] active_sel,
    output logic [4:0] src_stable,
    output logic       fail_flag
);

    logic [CNT_W-1:0] lim [NSRC];

    always_comb begin
        lim[IX_HXT] = CNT_W'(XTAL_CNT);
        lim[IX_LXT] = CNT_W'(XTAL_CNT);
        lim[IX_PLL] = CNT_W'(pll_limit(pll_cnt_sel));
        lim[IX_LRC] = CNT_W'(LRC_CNT);
        lim[IX_HRC] = CNT_W'(hrc_limit(hrc_cnt_sel));
    end

    for (genvar i = 0; i < NSRC; i++) begin : g_stab
        clksrc_stab_cnt #(.CNT_W(CNT_W)) u_cnt (
            .clk    (clk),
            .rst_n  (rst_n),
            .en     (src_en[i]),
            .tick   (src_tick[i]),
            .limit  (lim[i]),
            .stable (src_stable[i])
        );
    end

    clksrc_sw_fsm #(.BOOT_SEL(BOOT_SEL)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_sel    (req_sel),
        .stable     (src_stable),
        .fail_clr   (fail_clr),
        .active_sel (active_sel),
        .fail_flag  (fail_flag)
    );

endmodule

// File: rtl/clksrc_switch_chk.sv
module clksrc_switch_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [4:0] src_en,
    input logic [4:0] src_tick,
    input logic [2:0] active_sel,
    input logic [4:0] src_stable,
    input logic       fail_flag
);

    a_r1_legal_active: assert property (@(posedge clk) disable iff (!rst_n)
        active_sel inside {3'b000, 3'b001, 3'b010, 3'b011, 3'b111});

    a_r8_keep_on_fail: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fail_flag) |-> $stable(active_sel));

    a_r11_switch_clears_fail: assert property (@(posedge clk) disable iff (!rst_n)
        $changed(active_sel) |-> !fail_flag);

    for (genvar i = 0; i < 5; i++) begin : g_src
        a_r6_flag_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(src_stable[i]) |-> $past(src_en[i]));

        a_r12_flag_needs_tick: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(src_stable[i]) |-> $past(src_tick[i]));
    end

endmodule

bind clksrc_switch clksrc_switch_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .src_en     (src_en),
    .src_tick   (src_tick),
    .active_sel (active_sel),
    .src_stable (src_stable),
    .fail_flag  (fail_flag)
);

// File: tb/clksrc_switch_bench.sv
`timescale 1ns/1ps
module clksrc_switch_bench;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [4:0] src_en;
    logic [4:0] src_tick;
    logic [2:0] req_sel;
    logic       req_valid;
    logic [1:0] hrc_cnt_sel;
    logic       pll_cnt_sel;
    logic       fail_clr;
    logic [2:0] active_sel;
    logic [4:0] src_stable;
    logic       fail_flag;

    int total = 0;
    int bad   = 0;

    always #4 clk = ~clk;

    clksrc_switch u_clksrc_switch (
        .clk         (clk),
        .rst_n       (rst_n),
        .src_en      (src_en),
        .src_tick    (src_tick),
        .req_sel     (req_sel),
        .req_valid   (req_valid),
        .hrc_cnt_sel (hrc_cnt_sel),
        .pll_cnt_sel (pll_cnt_sel),
        .fail_clr    (fail_clr),
        .active_sel  (active_sel),
        .src_stable  (src_stable),
        .fail_flag   (fail_flag)
    );

    // vector: {req code[6:4], expected active[3:1], expected fail[0]}
    localparam logic [6:0] VEC [0:5] = '{
        {3'b010, 3'b111, 1'b1},   // PLL off: refused
        {3'b000, 3'b000, 1'b0},   // fast crystal stable: taken
        {3'b101, 3'b000, 1'b1},   // reserved: refused
        {3'b011, 3'b011, 1'b0},   // slow RC stable: taken
        {3'b001, 3'b011, 1'b1},   // slow crystal off: refused
        {3'b111, 3'b111, 1'b0}    // fast RC stable: taken
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    // enable source idx, tick it every 'period' cycles, report tick count at which stable rises
    task automatic measure(input int idx, input int n, input int period, input string req);
        int  ticks = 0;
        bit  seen  = 0;
        @(negedge clk);
        src_en[idx] = 1'b1;
        while (!seen && ticks < n + 8) begin
            for (int p = 1; p < period; p++) begin
                src_tick[idx] = 1'b0;
                @(negedge clk);
            end
            src_tick[idx] = 1'b1;
            @(negedge clk);
            ticks++;
            if (src_stable[idx]) seen = 1;
        end
        src_tick[idx] = 1'b0;
        check(seen && ticks == n, req, ticks, n);
    endtask

    task automatic drop(input int idx);
        @(negedge clk);
        src_en[idx] = 1'b0;
        @(negedge clk);
    endtask

    task automatic request(input logic [2:0] code);
        @(negedge clk);
        req_sel   = code;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        #(8 * 190000);
        total++;
        bad++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        summary();
    end

    initial begin
        rst_n       = 1'b0;
        src_en      = '0;
        src_tick    = '0;
        req_sel     = '0;
        req_valid   = 1'b0;
        hrc_cnt_sel = 2'b00;
        pll_cnt_sel = 1'b0;
        fail_clr    = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check(active_sel == 3'b111, "R1 boot source", active_sel, 7);
        check(src_stable == 5'b0, "R1 stable flags", src_stable, 0);
        check(fail_flag == 1'b0, "R1 fail flag", fail_flag, 0);

        // R2 fast crystal fixed length
        measure(0, 4096, 1, "R2 fast crystal count");

        // R12 slow crystal with sparse ticks still needs 4096 ticks
        measure(1, 4096, 3, "R12 sparse ticks / R2 slow crystal");
        drop(1);

        // R4 PLL lengths
        pll_cnt_sel = 1'b0;
        measure(2, 6144, 1, "R4 PLL short");
        drop(2);
        pll_cnt_sel = 1'b1;
        measure(2, 16128, 1, "R4 PLL long");
        drop(2);

        // R5 slow RC
        measure(3, 128, 1, "R5 slow RC count");

        // R6 disable clears flag, restart from zero after partial count
        drop(3);
        check(src_stable[3] == 1'b0, "R6 flag low when disabled", src_stable[3], 0);
        @(negedge clk);
        src_en[3] = 1'b1;
        for (int k = 0; k < 100; k++) begin
            src_tick[3] = 1'b1;
            @(negedge clk);
        end
        src_tick[3] = 1'b0;
        drop(3);
        measure(3, 128, 1, "R6 restart from zero");

        // R3 fast RC lengths
        hrc_cnt_sel = 2'b00;
        measure(4, 512, 1, "R3 fast RC 00");
        drop(4);
        hrc_cnt_sel = 2'b01;
        measure(4, 1024, 1, "R3 fast RC 01");
        drop(4);
        hrc_cnt_sel = 2'b10;
        measure(4, 2048, 1, "R3 fast RC 10");
        drop(4);
        hrc_cnt_sel = 2'b11;
        measure(4, 256, 1, "R3 fast RC 11");

        // table of switch requests (R7, R8, R9, R11)
        for (int v = 0; v < 6; v++) begin
            string tag;
            request(VEC[v][6:4]);
            if (!VEC[v][0])                         tag = "R7/R11 switch accepted";
            else if (VEC[v][6:4] inside {3'b100, 3'b101, 3'b110}) tag = "R9 reserved code";
            else                                    tag = "R8 unstable target";
            check(active_sel == VEC[v][3:1], {tag, " active"}, active_sel, VEC[v][3:1]);
            check(fail_flag == VEC[v][0], {tag, " fail"}, fail_flag, VEC[v][0]);
        end

        // R10 sticky flag and clear
        request(3'b110);
        check(fail_flag == 1'b1, "R9 reserved 110 fail", fail_flag, 1);
        repeat (5) @(negedge clk);
        check(fail_flag == 1'b1, "R10 flag sticky", fail_flag, 1);
        check(active_sel == 3'b111, "R9 active kept", active_sel, 7);
        fail_clr = 1'b1;
        @(negedge clk);
        fail_clr = 1'b0;
        check(fail_flag == 1'b0, "R10 clear pulse", fail_flag, 0);

        summary();
    end

endmodule